// File: doc/BRIEF.md
# Predicated Vector Integer Compare Unit

This block takes one compare instruction word together with two vector operands and a governing predicate, compares the operands element by element, and returns a destination predicate with four condition flags. The element width is picked per instruction from a two-bit size field, so one datapath handles 8, 16, 32 and 64-bit integers. Six relations are supported: equal, not equal, signed greater-or-equal, signed greater, unsigned higher-or-same and unsigned higher.

The predicate holds one bit per operand byte. Each element owns a slot of esize/8 predicate bits, and only the lowest bit of a slot has meaning. On the governing side that bit marks the element active. On the result side that bit carries the outcome, and the other bits of the slot are zero. Inactive elements give all-zero slots. The flags describe the result: N is the first active element's outcome, Z says no active element was true, C is the inverse of the last active element's outcome, and V is always zero.

Work enters and leaves through a valid/ready handshake with one registered stage. The latency is the same for every data value. A word that fails to decode is reported as undefined, and it carries no result.

Top module: `vcmp_pred_unit`

## Requirements
- R1: A word is legal only if bits[31:24]=8'h24, bit 21=0 and bits[15:13] is 3'b101, 3'b100 or 3'b000. Any other word gives out_undef=1 with out_pred, out_dst and all four flags zero.
- R2: The element size comes from bits[23:22]: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64.
- R3: Bit 4 picks the relation inside each group. Group 101 gives EQ when bit 4 is 0 and NE when it is 1. Group 100 gives signed GE when bit 4 is 0 and signed GT when it is 1. Group 000 gives unsigned HS when bit 4 is 0 and unsigned HI when it is 1.
- R4: The signed relations read elements as two's complement, and the unsigned ones read them as plain binary. For example, with 8-bit elements 0x80 is less than 0x01 under GT and greater under HI.
- R5: Element e, counted from 0 at the low end, reports its result at predicate bit e*esize/8. All other bits of its slot are zero.
- R6: An element is active when the governing bit at the lowest position of its slot is 1. Governing bits at other positions of the slot have no effect. Inactive elements give 0.
- R7: N equals the result of the lowest-numbered active element.
- R8: Z is 1 exactly when no active element compares true.
- R9: C is the inverse of the result of the highest-numbered active element, and V is always 0.
- R10: With no active element the flags are N=0, Z=1, C=1, V=0 and the result is all zero.
- R11: out_dst carries bits[3:0] of the accepted instruction word.
- R12: in_ready equals !out_valid || out_ready. A word accepted at a clock edge has its result valid after that edge. An output that is not taken stays stable until out_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request |
| in_instr | input | 32 | Compare instruction word |
| in_opa | input | VL_BITS | First vector operand |
| in_opb | input | VL_BITS | Second vector operand |
| in_gov | input | VL_BITS/8 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_pred | output | VL_BITS/8 | Destination predicate |
| out_dst | output | 4 | Destination predicate index |
| out_flag_n | output | 1 | First active element true |
| out_flag_z | output | 1 | No active element true |
| out_flag_c | output | 1 | Last active element not true |
| out_flag_v | output | 1 | Always zero |
| out_undef | output | 1 | Instruction word did not decode |

## Verification
The assertions check properties that must hold on every cycle. V stays clear. An undefined result is quiet. Results never land on inactive or non-head bits. Z and N are never both set, and an all-zero result sets Z and C. The handshake holds its output under backpressure and has one-cycle latency. Some behaviours only the bench scenarios can show, because they need known operands to compare against: the relation picked by each group and bit-4 combination, signed versus unsigned reading at each element width, which element N and C follow, and the decoding of malformed words.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'b00,
    ESZ_B16 = 2'b01,
    ESZ_B32 = 2'b10,
    ESZ_B64 = 2'b11
  } esz_e;

  typedef enum logic [2:0] {
    REL_EQ,
    REL_NE,
    REL_SGE,
    REL_SGT,
    REL_UHS,
    REL_UHI
  } rel_e;

  localparam logic [7:0] MAJOR_CODE = 8'h24;
  localparam logic [2:0] GRP_EQNE   = 3'b101;
  localparam logic [2:0] GRP_SIGNED = 3'b100;
  localparam logic [2:0] GRP_UNSGN  = 3'b000;

  // Widen a w-bit value held in the low bits of v to 65 bits, signed or not.
  function automatic logic signed [64:0] widen(logic [63:0] v, int unsigned w, logic sgn);
    logic [64:0] r;
    r = {1'b0, v};
    if (sgn && v[w-1]) begin
      for (int k = 0; k < 65; k++) begin
        if (k >= int'(w)) r[k] = 1'b1;
      end
    end
    return signed'(r);
  endfunction

  function automatic logic is_signed_rel(rel_e op);
    return (op == REL_SGE) || (op == REL_SGT);
  endfunction

  // Compare two w-bit elements under relation op.
  function automatic logic elem_cond(logic [63:0] a, logic [63:0] b, int unsigned w, rel_e op);
    logic signed [64:0] wa;
    logic signed [64:0] wb;
    logic r;
    wa = widen(a, w, is_signed_rel(op));
    wb = widen(b, w, is_signed_rel(op));
    case (op)
      REL_EQ:  r = (wa == wb);
      REL_NE:  r = (wa != wb);
      REL_SGE: r = (wa >= wb);
      REL_SGT: r = (wa >  wb);
      REL_UHS: r = (wa >= wb);
      REL_UHI: r = (wa >  wb);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
  import vcmp_pkg::*;
(
  input  logic [31:0] instr,
  output logic        legal,
  output rel_e        rel,
  output esz_e        esz,
  output logic [3:0]  dst
);

  logic fixed_ok;
  logic [2:0] grp;
  logic sel;

  assign fixed_ok = (instr[31:24] == MAJOR_CODE) && !instr[21];
  assign grp      = instr[15:13];
  assign sel      = instr[4];
  assign esz      = esz_e'(instr[23:22]);
  assign dst      = instr[3:0];

  always_comb begin
    legal = fixed_ok;
    rel   = REL_EQ;
    case (grp)
      GRP_EQNE:   rel = sel ? REL_NE  : REL_EQ;
      GRP_SIGNED: rel = sel ? REL_SGT : REL_SGE;
      GRP_UNSGN:  rel = sel ? REL_UHI : REL_UHS;
      default:    legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/vcmp_lane_array.sv
module vcmp_lane_array
  import vcmp_pkg::*;
#(
  parameter int VL_BITS = 256,
  parameter int PL_BITS = VL_BITS / 8
) (
  input  logic [VL_BITS-1:0] opa,
  input  logic [VL_BITS-1:0] opb,
  input  logic [PL_BITS-1:0] gov,
  input  esz_e               esz,
  input  rel_e               rel,
  output logic [PL_BITS-1:0] res
);

  localparam int NUM_SIZES = 4;

  logic [PL_BITS-1:0] per_size [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int EB   = 8 << s;
    localparam int STEP = EB / 8;
    logic [PL_BITS-1:0] hit;
    for (genvar p = 0; p < PL_BITS; p++) begin : g_pos
      if ((p % STEP) == 0) begin : g_head
        assign hit[p] = gov[p] &
          elem_cond(64'(opa[p*8 +: EB]), 64'(opb[p*8 +: EB]), EB, rel);
      end else begin : g_tail
        assign hit[p] = 1'b0;
      end
    end
    assign per_size[s] = hit;
  end

  assign res = per_size[esz];

endmodule

// File: rtl/vcmp_flags.sv
module vcmp_flags
  import vcmp_pkg::*;
#(
  parameter int PL_BITS = 32
) (
  input  logic [PL_BITS-1:0] res,
  input  logic [PL_BITS-1:0] gov,
  input  esz_e               esz,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_c
);

  logic [PL_BITS-1:0] active;
  logic               seen;

  always_comb begin
    active = '0;
    for (int i = 0; i < PL_BITS; i++) begin
      if ((i % (1 << esz)) == 0) active[i] = gov[i];
    end
    flag_n = 1'b0;
    flag_c = 1'b1;
    seen   = 1'b0;
    for (int i = 0; i < PL_BITS; i++) begin
      if (active[i]) begin
        if (!seen) flag_n = res[i];
        seen   = 1'b1;
        flag_c = ~res[i];
      end
    end
    flag_z = ~|(res & active);
  end

endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit
  import vcmp_pkg::*;
#(
  parameter int VL_BITS = 256,
  parameter int PL_BITS = VL_BITS / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_instr,
  input  logic [VL_BITS-1:0] in_opa,
  input  logic [VL_BITS-1:0] in_opb,
  input  logic [PL_BITS-1:0] in_gov,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PL_BITS-1:0] out_pred,
  output logic [3:0]         out_dst,
  output logic               out_flag_n,
  output logic               out_flag_z,
  output logic               out_flag_c,
  output logic               out_flag_v,
  output logic               out_undef
);

  // Named internal events for the assertions.
  logic               dec_legal;
  rel_e               dec_rel;
  esz_e               dec_esz;
  logic [3:0]         dec_dst;
  logic [PL_BITS-1:0] lane_res;
  logic               cmb_n, cmb_z, cmb_c;
  logic               accept;
  esz_e               held_esz;
  logic [PL_BITS-1:0] held_heads;

  vcmp_decode u_decode (
    .instr (in_instr),
    .legal (dec_legal),
    .rel   (dec_rel),
    .esz   (dec_esz),
    .dst   (dec_dst)
  );

  vcmp_lane_array #(.VL_BITS(VL_BITS), .PL_BITS(PL_BITS)) u_lanes (
    .opa (in_opa),
    .opb (in_opb),
    .gov (in_gov),
    .esz (dec_esz),
    .rel (dec_rel),
    .res (lane_res)
  );

  vcmp_flags #(.PL_BITS(PL_BITS)) u_flags (
    .res    (lane_res),
    .gov    (in_gov),
    .esz    (dec_esz),
    .flag_n (cmb_n),
    .flag_z (cmb_z),
    .flag_c (cmb_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_pred   <= '0;
      out_dst    <= '0;
      out_flag_n <= 1'b0;
      out_flag_z <= 1'b0;
      out_flag_c <= 1'b0;
      out_flag_v <= 1'b0;
      out_undef  <= 1'b0;
      held_esz   <= ESZ_B8;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_undef  <= !dec_legal;
      out_pred   <= dec_legal ? lane_res : '0;
      out_dst    <= dec_legal ? dec_dst  : '0;
      out_flag_n <= dec_legal && cmb_n;
      out_flag_z <= dec_legal && cmb_z;
      out_flag_c <= dec_legal && cmb_c;
      out_flag_v <= 1'b0;
      held_esz   <= dec_esz;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  always_comb begin
    held_heads = '0;
    for (int i = 0; i < PL_BITS; i++) begin
      if ((i % (1 << held_esz)) == 0) held_heads[i] = 1'b1;
    end
  end

  assert_undef_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> (out_pred == '0) && !out_flag_n && !out_flag_z && !out_flag_c);

  assert_head_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_pred & ~held_heads) == '0));

  assert_inactive_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_legal |-> ((lane_res & ~in_gov) == '0));

  assert_z_excl_n_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_flag_z && out_flag_n));

  assert_empty_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_undef && (out_pred == '0) |-> out_flag_z && out_flag_c && !out_flag_n);

  assert_v_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_flag_v);

  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pred) && $stable(out_dst)
                                 && $stable(out_undef));

endmodule

// File: tb/vcmp_pred_unit_bench.sv
module vcmp_pred_unit_bench;
  localparam int VL = 256;
  localparam int PL = VL / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_instr = '0;
  logic [VL-1:0] in_opa = '0;
  logic [VL-1:0] in_opb = '0;
  logic [PL-1:0] in_gov = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PL-1:0] out_pred;
  logic [3:0]    out_dst;
  logic          out_flag_n, out_flag_z, out_flag_c, out_flag_v, out_undef;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  vcmp_pred_unit #(.VL_BITS(VL)) u_vcmp_pred_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_instr, .in_opa, .in_opb, .in_gov,
    .out_valid, .out_ready, .out_pred, .out_dst, .out_flag_n, .out_flag_z,
    .out_flag_c, .out_flag_v, .out_undef
  );

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [1:0] sz, logic [2:0] grp, logic ne, logic [3:0] pd);
    return {8'h24, sz, 1'b0, 5'd7, grp, 3'd2, 5'd9, ne, pd};
  endfunction

  // Reference: restated from the requirements using bias-flipped unsigned compare.
  task automatic ref_model(input logic [31:0] ins, input logic [VL-1:0] a, input logic [VL-1:0] b,
                           input logic [PL-1:0] g, output logic [PL-1:0] pr,
                           output logic [3:0] nzcv, output logic und, output logic [3:0] pd);
    int w, step;
    logic sgn, lt, eq, r, n, z, c, any;
    logic [63:0] x, y, msk;
    pr = '0; nzcv = 4'b0000; pd = 4'd0;
    und = !(ins[31:24] == 8'h24 && ins[21] == 1'b0 &&
            (ins[15:13] == 3'b101 || ins[15:13] == 3'b100 || ins[15:13] == 3'b000));
    if (und) return;
    pd = ins[3:0];
    w = 8 << ins[23:22];
    step = w / 8;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    sgn = (ins[15:13] == 3'b100);
    n = 1'b0; c = 1'b1; z = 1'b1; any = 1'b0;
    for (int p = 0; p < PL; p += step) begin
      if (g[p]) begin
        x = 64'(a >> (p * 8)) & msk;
        y = 64'(b >> (p * 8)) & msk;
        if (sgn) begin
          x = x ^ (64'd1 << (w - 1));
          y = y ^ (64'd1 << (w - 1));
        end
        lt = x < y; eq = x == y;
        case (ins[15:13])
          3'b101:  r = ins[4] ? !eq : eq;
          default: r = ins[4] ? (!lt && !eq) : !lt;
        endcase
        pr[p] = r;
        if (!any) n = r;
        any = 1'b1;
        c = !r;
        if (r) z = 1'b0;
      end
    end
    nzcv = {n, z, c, 1'b0};
  endtask

  // Present one word, let it pass one register stage, compare against the model.
  task automatic run_op(string req, logic [31:0] ins, logic [VL-1:0] a, logic [VL-1:0] b,
                        logic [PL-1:0] g);
    logic [PL-1:0] ep; logic [3:0] ef; logic eu; logic [3:0] ed;
    ref_model(ins, a, b, g, ep, ef, eu, ed);
    @(negedge clk);
    in_instr = ins; in_opa = a; in_opb = b; in_gov = g; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R12 valid"}, 256'(out_valid), 256'(1));
    check({req, " pred"}, 256'(out_pred), 256'(ep));
    check({req, " flags R7 R8 R9"}, 256'({out_flag_n, out_flag_z, out_flag_c, out_flag_v}), 256'(ef));
    check({req, " undef R1"}, 256'(out_undef), 256'(eu));
    check({req, " dst R11"}, 256'(out_dst), 256'(ed));
  endtask

  task automatic t_reset;
    check("reset R12 valid low", 256'(out_valid), 256'(0));
    check("reset R12 ready", 256'(in_ready), 256'(1));
    check("reset pred zero", 256'(out_pred), 256'(0));
  endtask

  task automatic t_relations;
    logic [VL-1:0] a, b;
    for (int k = 0; k < PL; k++) begin
      a[k*8 +: 8] = 8'(k * 37);
      b[k*8 +: 8] = (k % 3 == 0) ? 8'(k * 37) : 8'(k * 11 + 5);
    end
    run_op("R3 EQ", mk(2'b00, 3'b101, 1'b0, 4'd1), a, b, '1);
    run_op("R3 NE", mk(2'b00, 3'b101, 1'b1, 4'd2), a, b, '1);
    run_op("R3 SGE", mk(2'b00, 3'b100, 1'b0, 4'd3), a, b, '1);
    run_op("R3 SGT", mk(2'b00, 3'b100, 1'b1, 4'd4), a, b, '1);
    run_op("R3 UHS", mk(2'b00, 3'b000, 1'b0, 4'd5), a, b, '1);
    run_op("R3 UHI", mk(2'b00, 3'b000, 1'b1, 4'd15), a, b, '1);
  endtask

  task automatic t_sign;
    logic [VL-1:0] a, b;
    for (int k = 0; k < PL; k++) begin a[k*8 +: 8] = 8'h80; b[k*8 +: 8] = 8'h01; end
    run_op("R4 signed GT", mk(2'b00, 3'b100, 1'b1, 4'd6), a, b, '1);
    check("R4 signed GT all false", 256'(out_pred), 256'(0));
    run_op("R4 unsigned HI", mk(2'b00, 3'b000, 1'b1, 4'd6), a, b, '1);
    check("R4 unsigned HI all true", 256'(out_pred), 256'({PL{1'b1}}));
  endtask

  task automatic t_sizes;
    logic [VL-1:0] a, b;
    for (int sz = 0; sz < 4; sz++) begin
      for (int k = 0; k < VL / 32; k++) begin
        a[k*32 +: 32] = $urandom();
        b[k*32 +: 32] = (k % 2 == 0) ? a[k*32 +: 32] : $urandom();
      end
      run_op("R2 R5 size sweep GE", mk(2'(sz), 3'b100, 1'b0, 4'd8), a, b, '1);
      run_op("R2 R5 size sweep EQ", mk(2'(sz), 3'b101, 1'b0, 4'd9), a, b, '1);
    end
    a = '0; b = '0;
    run_op("R5 64-bit heads", mk(2'b11, 3'b101, 1'b0, 4'd0), a, b, '1);
    check("R5 64-bit head bits only", 256'(out_pred), 256'(32'h01010101));
  endtask

  task automatic t_governing;
    logic [VL-1:0] a, b;
    a = '0; b = '0;
    run_op("R6 tail gov bits ignored", mk(2'b10, 3'b101, 1'b0, 4'd3), a, b, 32'hEEEEEEEE);
    check("R6 R10 no active pred", 256'(out_pred), 256'(0));
    check("R10 no active flags", 256'({out_flag_n, out_flag_z, out_flag_c, out_flag_v}), 256'(4'b0110));
    run_op("R6 sparse gov", mk(2'b01, 3'b101, 1'b0, 4'd3), a, b, 32'h00F0_0104);
    check("R6 sparse expected", 256'(out_pred), 256'(32'h0050_0104));
  endtask

  task automatic t_flags;
    logic [VL-1:0] a, b;
    a = '0; b = '0;
    a[7:0] = 8'h11;
    run_op("R7 first false", mk(2'b00, 3'b101, 1'b0, 4'd4), a, b, '1);
    check("R7 N low R9 C low", 256'({out_flag_n, out_flag_c}), 256'(2'b00));
    a = '0; a[VL-8 +: 8] = 8'h22;
    run_op("R9 last false", mk(2'b00, 3'b101, 1'b0, 4'd4), a, b, 32'h8000_0010);
    check("R9 N high C high", 256'({out_flag_n, out_flag_z, out_flag_c}), 256'(3'b101));
    run_op("R8 none true", mk(2'b00, 3'b101, 1'b1, 4'd4), '0, '0, '1);
    check("R8 Z set", 256'(out_flag_z), 256'(1));
  endtask

  task automatic t_undef;
    logic [31:0] w;
    w = mk(2'b00, 3'b101, 1'b0, 4'd7); w[31:24] = 8'h25;
    run_op("R1 bad major", w, '1, '0, '1);
    w = mk(2'b00, 3'b101, 1'b0, 4'd7); w[21] = 1'b1;
    run_op("R1 bit21 set", w, '1, '0, '1);
    run_op("R1 group 110", mk(2'b00, 3'b110, 1'b0, 4'd7), '1, '0, '1);
    run_op("R1 group 001", mk(2'b01, 3'b001, 1'b1, 4'd7), '1, '0, '1);
  endtask

  task automatic t_backpressure;
    logic [VL-1:0] a;
    logic [PL-1:0] held;
    a = '0;
    @(negedge clk);
    out_ready = 1'b0;
    in_instr = mk(2'b00, 3'b101, 1'b0, 4'd10); in_opa = a; in_opb = a; in_gov = '1;
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_instr = mk(2'b00, 3'b101, 1'b1, 4'd12);
    check("R12 ready low when full", 256'(in_ready), 256'(0));
    held = out_pred;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      check("R12 held pred", 256'(out_pred), 256'(held));
      check("R12 held dst", 256'(out_dst), 256'(10));
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R12 next word taken", 256'(out_dst), 256'(12));
    check("R12 next pred", 256'(out_pred), 256'(0));
    @(posedge clk); @(negedge clk);
    check("R12 drained", 256'(out_valid), 256'(0));
  endtask

  task automatic t_random;
    logic [VL-1:0] a, b; logic [PL-1:0] g;
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < VL / 32; k++) begin
        a[k*32 +: 32] = $urandom();
        b[k*32 +: 32] = (t % 3 == 0) ? a[k*32 +: 32] ^ (32'd1 << (t % 32)) : $urandom();
      end
      g = $urandom();
      run_op("R3 R4 R6 random", {8'h24, 2'(t % 4), 1'b0, 5'(t), 3'(t % 2 == 0 ? 5 : (t % 3 == 0 ? 4 : 0)),
             3'(t), 5'(t + 1), 1'(t / 4), 4'(t)}, a, b, g);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_relations();
    t_sign();
    t_sizes();
    t_governing();
    t_flags();
    t_undef();
    t_backpressure();
    t_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule